// File: doc/BRIEF.md
# SCSI Host Controller Interrupt and Status Register Window

This block is the byte-wide register window that a host processor uses to take interrupts from a simple SCSI host controller. It decodes a host byte address into one of sixteen register slots by shifting the address right by a parameterised amount. Host writes and host reads go to two separate backing arrays. The write-side array is brought out whole so that neighbouring controller logic can read what software programmed.

Events inside the controller request an interrupt. Each request arrives as a one-cycle pulse that carries a bus-phase status value, an interrupt-reason byte and a sequence-step value. The block latches all three in one cycle, sets the pending flag in the status register and drives a single level interrupt line.

Software acknowledges the interrupt by reading the reason register. That read returns the latched reason. At the clock edge that ends the access it also clears the reason register, the pending flag and the count-zero status flag, forces the step register to 4 and drops the interrupt line.

Top module: `hba_intr_regfile`

## Requirements
- R1: The register index is bits [SHIFT+3:SHIFT] of `bus_addr`. The low SHIFT address bits and the bits above the index have no effect on which register is reached.
- R2: After `rst_n` is deasserted, every read-side register reads 0x00 except index 8, which reads 0x07, and index 14, which reads 0x04. `irq` is low and every byte of `wreg_file` is zero.
- R3: An `ev_valid` pulse loads status (index 4) with {1'b1, `ev_status`}, reason (index 5) with `ev_reason` and step (index 6) with `ev_step`. These values are visible from the next cycle, and `irq` is high from the next cycle. Status bits [2:0] hold the bus phase: 0 data out, 1 data in, 2 command, 3 status, 6 message out, 7 message in. Status bit 4 means transfer count zero. Reason bits: 0x08 function complete, 0x10 bus service, 0x20 disconnect, 0x80 bus reset.
- R4: An event that arrives while an interrupt is already pending replaces all three values and keeps `irq` high.
- R5: A host read of index 5 returns the value held before the access. From the next cycle, index 5 reads 0, status bits 7 and 4 are clear while the other status bits are kept, index 6 reads 4, and `irq` is low. Reads of any other index change nothing.
- R6: When an event and a read of index 5 fall in the same cycle, the read still returns the old reason, and the event values and a high `irq` are what remain afterwards.
- R7: A host write to index 0 or index 1 clears status bit 4 and leaves the other status bits unchanged. The written byte appears in `wreg_file`.
- R8: Host writes to indices 2 to 7, 9 and 10 update only `wreg_file`. Reads of those indices are unchanged by them.
- R9: Host writes to index 8 and to indices 11 to 15 update both `wreg_file` and the value read back at the same index.
- R10: A one-cycle `soft_rst` pulse restores exactly the state that R2 describes. It takes priority over an event in the same cycle.
- R11: `irq` always equals status bit 7.
- R12: A read of index 5 with no interrupt pending returns 0, leaves `irq` low and still sets index 6 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous pulse that clears the block like a reset |
| bus_addr | input | ADDR_W | Host byte address |
| rd_en | input | 1 | Host read strobe; side effects occur at the clock edge |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write byte |
| rd_data | output | 8 | Read-side register at the addressed index while `rd_en` is high, else 0 |
| ev_valid | input | 1 | Interrupt request pulse from controller logic |
| ev_status | input | 7 | Status bits [6:0] to latch |
| ev_reason | input | 8 | Interrupt reason byte to latch |
| ev_step | input | 8 | Sequence step value to latch |
| irq | output | 1 | Level interrupt line |
| wreg_file | output | 128 | Write-side array; byte i is register index i |

## Verification
The bench targets the acknowledge read. A design that cleared the reason register before returning it would hand software a zero reason. A design that wiped the whole status byte would lose the bus phase. The bench also collides an event with that read in the same cycle. A design that gave the read priority would drop a fresh interrupt and leave `irq` low. It checks writes to the count registers and to the write-only slots, which catch a design that clears the wrong status bit or leaks a write into the read side. It also reaches registers through addresses with junk in the low bits, which exposes a wrong shift.

// File: rtl/hba_regs_pkg.sv
package hba_regs_pkg;
  localparam int NREGS = 16;
  localparam int IDX_W = 4;

  localparam logic [3:0] IX_TC0    = 4'd0;
  localparam logic [3:0] IX_TC1    = 4'd1;
  localparam logic [3:0] IX_STATUS = 4'd4;
  localparam logic [3:0] IX_REASON = 4'd5;
  localparam logic [3:0] IX_STEP   = 4'd6;
  localparam logic [3:0] IX_CFGA   = 4'd8;
  localparam logic [3:0] IX_CHIPID = 4'd14;

  localparam int ST_PEND = 7;
  localparam int ST_TCZ  = 4;
  localparam logic [7:0] STEP_AFTER_ACK = 8'h04;

  // register index from a byte address
  function automatic logic [IDX_W-1:0] idx_of(input logic [31:0] a, input int sh);
    logic [31:0] s;
    s = a >> sh;
    return s[IDX_W-1:0];
  endfunction

  // host writes that also land in the read-side array
  function automatic logic mirrors_read(input logic [IDX_W-1:0] i);
    return (i == IX_CFGA) || (i >= 4'd11);
  endfunction

  function automatic logic [7:0] rd_reset_val(input int i);
    if (i == int'(IX_CFGA))   return 8'h07;
    if (i == int'(IX_CHIPID)) return 8'h04;
    return 8'h00;
  endfunction
endpackage

// File: rtl/hba_addr_dec.sv
module hba_addr_dec
  import hba_regs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SHIFT  = 2
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              rd_en,
  input  logic              wr_en,
  output logic [IDX_W-1:0]  idx,
  output logic              ack_rd,
  output logic              tc_wr,
  output logic              mirror_wr
);
  always_comb begin
    idx       = idx_of(32'(bus_addr), SHIFT);
    ack_rd    = rd_en && (idx == IX_REASON);
    tc_wr     = wr_en && ((idx == IX_TC0) || (idx == IX_TC1));
    mirror_wr = wr_en && mirrors_read(idx);
  end
endmodule

// File: rtl/hba_wr_bank.sv
module hba_wr_bank
  import hba_regs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 soft_rst,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     idx,
  input  logic [7:0]           wr_data,
  output logic [NREGS*8-1:0]   wreg_file
);
  for (genvar g = 0; g < NREGS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        wreg_file[g*8 +: 8] <= 8'h00;
      else if (soft_rst)
        wreg_file[g*8 +: 8] <= 8'h00;
      else if (wr_en && (idx == IDX_W'(g)))
        wreg_file[g*8 +: 8] <= wr_data;
    end
  end
endmodule

// File: rtl/hba_rd_bank.sv
module hba_rd_bank
  import hba_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [IDX_W-1:0]  idx,
  input  logic              rd_en,
  input  logic              ack_rd,
  input  logic              tc_wr,
  input  logic              mirror_wr,
  input  logic [7:0]        wr_data,
  input  logic              ev_valid,
  input  logic [6:0]        ev_status,
  input  logic [7:0]        ev_reason,
  input  logic [7:0]        ev_step,
  output logic [7:0]        rd_data,
  output logic              irq
);
  logic [7:0] rregs [NREGS];
  logic       irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) rregs[i] <= rd_reset_val(i);
      irq_q <= 1'b0;
    end else if (soft_rst) begin
      for (int i = 0; i < NREGS; i++) rregs[i] <= rd_reset_val(i);
      irq_q <= 1'b0;
    end else begin
      if (mirror_wr) rregs[idx] <= wr_data;
      if (tc_wr) rregs[IX_STATUS][ST_TCZ] <= 1'b0;
      if (ack_rd) begin
        rregs[IX_REASON]          <= 8'h00;
        rregs[IX_STATUS][ST_TCZ]  <= 1'b0;
        rregs[IX_STATUS][ST_PEND] <= 1'b0;
        rregs[IX_STEP]            <= STEP_AFTER_ACK;
        irq_q                     <= 1'b0;
      end
      if (ev_valid) begin
        rregs[IX_STATUS] <= {1'b1, ev_status};
        rregs[IX_REASON] <= ev_reason;
        rregs[IX_STEP]   <= ev_step;
        irq_q            <= 1'b1;
      end
    end
  end

  assign rd_data = rd_en ? rregs[idx] : 8'h00;
  assign irq     = irq_q;

  assert_irq_tracks_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == rregs[IX_STATUS][ST_PEND]);
  assert_event_raises_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !soft_rst) |=> irq_q);
  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !ev_valid && !soft_rst) |=>
      (!irq_q && rregs[IX_REASON] == 8'h00 && rregs[IX_STEP] == STEP_AFTER_ACK));
  assert_event_beats_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && ev_valid && !soft_rst) |=> (irq_q && rregs[IX_STATUS][ST_PEND]));
  assert_tc_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_wr && !ev_valid && !soft_rst) |=> !rregs[IX_STATUS][ST_TCZ]);
  assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!irq_q && rregs[IX_CFGA] == 8'h07 && rregs[IX_CHIPID] == 8'h04));
endmodule

// File: rtl/hba_intr_regfile.sv
module hba_intr_regfile
  import hba_regs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SHIFT  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                rd_en,
  input  logic                wr_en,
  input  logic [7:0]          wr_data,
  output logic [7:0]          rd_data,
  input  logic                ev_valid,
  input  logic [6:0]          ev_status,
  input  logic [7:0]          ev_reason,
  input  logic [7:0]          ev_step,
  output logic                irq,
  output logic [NREGS*8-1:0]  wreg_file
);
  logic [IDX_W-1:0] idx;
  logic             ack_rd;
  logic             tc_wr;
  logic             mirror_wr;

  hba_addr_dec #(.ADDR_W(ADDR_W), .SHIFT(SHIFT)) u_dec (
    .bus_addr (bus_addr),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .idx      (idx),
    .ack_rd   (ack_rd),
    .tc_wr    (tc_wr),
    .mirror_wr(mirror_wr)
  );

  hba_wr_bank u_wr (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .wr_en    (wr_en),
    .idx      (idx),
    .wr_data  (wr_data),
    .wreg_file(wreg_file)
  );

  hba_rd_bank u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .idx      (idx),
    .rd_en    (rd_en),
    .ack_rd   (ack_rd),
    .tc_wr    (tc_wr),
    .mirror_wr(mirror_wr),
    .wr_data  (wr_data),
    .ev_valid (ev_valid),
    .ev_status(ev_status),
    .ev_reason(ev_reason),
    .ev_step  (ev_step),
    .rd_data  (rd_data),
    .irq      (irq)
  );
endmodule

// File: tb/sim_hba_intr_regfile.sv
module sim_hba_intr_regfile;
  localparam int AW = 8;
  localparam int SH = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic rd_en = 1'b0, wr_en = 1'b0, ev_valid = 1'b0;
  logic [7:0] wr_data = '0, ev_reason = '0, ev_step = '0;
  logic [6:0] ev_status = '0;
  logic [7:0] rd_data;
  logic irq;
  logic [127:0] wreg_file;

  int errors = 0;
  int checks = 0;
  int rm [16];
  int wm [16];
  int irq_m;

  always #2 clk = ~clk;

  hba_intr_regfile #(.ADDR_W(AW), .SHIFT(SH)) u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .bus_addr(bus_addr),
    .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ev_valid(ev_valid), .ev_status(ev_status), .ev_reason(ev_reason),
    .ev_step(ev_step), .irq(irq), .wreg_file(wreg_file));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) begin rm[i] = 0; wm[i] = 0; end
    rm[8] = 7; rm[14] = 4; irq_m = 0;
  endtask

  // one cycle: compare at negedge+1, then apply the reference update at posedge
  task automatic cyc(input string tag);
    int ix;
    ix = (int'(bus_addr) / (1 << SH)) % 16;
    #1;
    chk({tag, " irq"}, int'(irq), irq_m);
    chk({tag, " irq_flag(R11)"}, int'(irq), (rm[4] / 128) % 2);
    if (rd_en) chk({tag, " rd_data"}, int'(rd_data), rm[ix]);
    for (int i = 0; i < 16; i++)
      if (int'(wreg_file[i*8 +: 8]) != wm[i]) chk({tag, " wreg_file"}, int'(wreg_file[i*8 +: 8]), wm[i]);
    @(posedge clk);
    if (soft_rst) model_reset();
    else begin
      if (wr_en) begin
        wm[ix] = int'(wr_data);
        if (ix == 8 || ix >= 11) rm[ix] = int'(wr_data);
        if (ix < 2 && (rm[4] & 16) != 0) rm[4] = rm[4] - 16;
      end
      if (rd_en && ix == 5) begin
        rm[5] = 0; rm[6] = 4; irq_m = 0;
        rm[4] = rm[4] % 128;
        if ((rm[4] & 16) != 0) rm[4] = rm[4] - 16;
      end
      if (ev_valid) begin
        rm[4] = 128 + int'(ev_status); rm[5] = int'(ev_reason); rm[6] = int'(ev_step); irq_m = 1;
      end
    end
    @(negedge clk);
    rd_en = 0; wr_en = 0; ev_valid = 0; soft_rst = 0;
  endtask

  task automatic rd(input int ix, input int junk, input string tag);
    bus_addr = AW'((ix << SH) | junk); rd_en = 1; cyc(tag);
  endtask
  task automatic wr(input int ix, input int d, input string tag);
    bus_addr = AW'(ix << SH); wr_data = 8'(d); wr_en = 1; cyc(tag);
  endtask
  task automatic ev(input int st, input int rs, input int sp, input string tag);
    ev_status = 7'(st); ev_reason = 8'(rs); ev_step = 8'(sp); ev_valid = 1; cyc(tag);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    // R2 reset values
    for (int i = 0; i < 16; i++) if (i != 5) rd(i, 0, "R2");
    rd(5, 0, "R2");
    // R1 address junk in low and high bits
    rd(8, 3, "R1"); rd(14, 2, "R1");
    bus_addr = AW'((1 << (SH + 4)) | (8 << SH) | 1); rd_en = 1; cyc("R1");
    // R3 event then readback
    ev(7'h11, 8'h18, 3, "R3");
    rd(4, 0, "R3"); rd(6, 0, "R3"); rd(4, 1, "R3");
    // R4 replace while pending
    ev(7'h13, 8'h08, 2, "R4");
    rd(4, 0, "R4"); rd(6, 0, "R4");
    // R5 acknowledge
    rd(5, 0, "R5"); rd(5, 0, "R5 cleared"); rd(4, 0, "R5"); rd(6, 0, "R5");
    // R12 acknowledge with nothing pending
    wr(11, 8'h5A, "R12 prep");
    rd(5, 0, "R12"); rd(6, 0, "R12");
    // R7 count register writes
    ev(7'h17, 8'h10, 1, "R7 prep"); wr(0, 8'h34, "R7"); rd(4, 0, "R7");
    ev(7'h16, 8'h20, 1, "R7 prep"); wr(1, 8'h12, "R7"); rd(4, 0, "R7");
    // R6 collision
    ev(7'h02, 8'h80, 5, "R6 prep");
    bus_addr = AW'(5 << SH); rd_en = 1;
    ev_status = 7'h01; ev_reason = 8'h18; ev_step = 8'h03; ev_valid = 1; cyc("R6");
    rd(4, 0, "R6"); rd(6, 0, "R6");
    // R8 write-only slots
    foreach (rm[i]) if ((i >= 2 && i <= 7) || i == 9 || i == 10) wr(i, 8'hA0 + i, "R8");
    foreach (rm[i]) if ((i >= 2 && i <= 7 && i != 5) || i == 9 || i == 10) rd(i, 0, "R8");
    // R9 mirrored slots
    foreach (rm[i]) if (i == 8 || i >= 11) wr(i, 8'hC0 + i, "R9");
    foreach (rm[i]) if (i == 8 || i >= 11) rd(i, 2, "R9");
    // R10 soft reset, colliding with an event
    ev(7'h05, 8'h08, 2, "R10 prep");
    soft_rst = 1; ev_valid = 1; ev_status = 7'h7F; ev_reason = 8'hFF; ev_step = 8'hFF; cyc("R10");
    for (int i = 0; i < 16; i++) rd(i, 0, "R10");
    // mixed traffic against the reference
    for (int n = 0; n < 400; n++) begin
      int r;
      r = $urandom % 8;
      bus_addr = AW'($urandom);
      rd_en = (r < 3); wr_en = (r >= 3 && r < 5); wr_data = 8'($urandom);
      ev_valid = ($urandom % 5 == 0);
      ev_status = 7'($urandom); ev_reason = 8'($urandom); ev_step = 8'($urandom);
      soft_rst = ($urandom % 97 == 0);
      cyc("R11 mix");
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule